// File: doc/BRIEF.md
# Low-Power Mode State Controller

This block is the mode sequencer of a power-management controller. After a system reset it sits in Off. A turn-on event starts a Cold Start. Both resets stay asserted while a reset timer counts down. When the timer expires the controller enters the running (Watchdog) state and releases both resets. From the running state software can request one of two low-power off states.

The first, User Off, keeps the processor reset released so the core keeps its state, and it can keep a slow processor clock alive. A turn-on from User Off returns through Warm Start, which needs no new cold boot. The second, Memory Hold, keeps only the chosen memory supplies alive and asserts both resets. It returns through Cold Start and flags a memory-hold interrupt.

Each of the switcher domains has two keep-on bits, one per low-power state. A power-cut indication sends the controller to Off from any state. All configuration bits are plain inputs. Every output is registered and changes on the same clock edge as the mode.

Top module: `lpm_state_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the controller enters Off (mode code 0). Both resets go low, `dom_on_o` goes to 0, both clock enables go to 0 and both interrupt flags go to 0.
- R2: A `turn_on_i` pulse in Off enters Cold Start (code 1) with both resets low and `dom_on_o` = 0. The mode stays there for `RST_TICKS`+1 cycles and then moves to Watchdog (code 2).
- R3: In Watchdog, both resets are high and `periph_clk_en_o` is 1. Every bit of `dom_on_o` is 1, and `mcu_clk_en_o` equals `mcu_clk_en_i`.
- R4: `user_off_cmd_i` in Watchdog enters User Off (code 3). There the peripheral reset is low, the processor reset is high, `periph_clk_en_o` is 0 and `dom_on_o` equals `uo_keep_i`.
- R5: In User Off, `mcu_clk_en_o` = (`mcu_clk_en_i` AND `uo_clk_keep_i`) OR `clk_retain_i`.
- R6: `mem_hold_cmd_i` in Watchdog, without `user_off_cmd_i`, enters Memory Hold (code 4). `user_off_cmd_i` wins when both are high. In Memory Hold both resets are low, `dom_on_o` equals `mh_keep_i` and the processor clock is off.
- R7: `turn_on_i` in User Off enters Warm Start (code 5). There the peripheral reset is low and the processor reset is high. `dom_on_o` equals `uo_keep_i`, and `mcu_clk_en_o` equals `mcu_clk_en_i`. Warm Start lasts `RST_TICKS`+1 cycles and then moves to Watchdog.
- R8: `turn_on_i` in Memory Hold enters Cold Start and sets `mh_irq_o` on that same edge. During that Cold Start `dom_on_o` equals `mh_keep_i`.
- R9: Leaving Warm Start for Watchdog sets `warm_irq_o` on the same edge that raises the peripheral reset.
- R10: Both flags are sticky. A one-cycle `irq_clr_i` clears them, and a flag set in the same cycle wins over the clear.
- R11: `pwr_cut_i` sends the controller to Off on the next edge from any state. It takes priority over all other inputs except `rst`.
- R12: No timer runs in User Off or Memory Hold, so they persist until a turn-on event or a power cut. `turn_on_i` has no effect in Cold Start, Warm Start or Watchdog. The off commands have no effect outside Watchdog.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| turn_on_i | input | 1 | Turn-on event |
| pwr_cut_i | input | 1 | Main supply lost |
| user_off_cmd_i | input | 1 | Request User Off |
| mem_hold_cmd_i | input | 1 | Request Memory Hold |
| irq_clr_i | input | 1 | Clear both interrupt flags |
| mcu_clk_en_i | input | 1 | Processor slow-clock enable bit |
| uo_clk_keep_i | input | 1 | Keep processor clock in User Off |
| clk_retain_i | input | 1 | Force processor clock retention in User Off |
| uo_keep_i | input | N_DOM | Per-domain keep-on bits for User Off |
| mh_keep_i | input | N_DOM | Per-domain keep-on bits for Memory Hold |
| periph_rst_n_o | output | 1 | Peripheral reset, active low |
| proc_rst_n_o | output | 1 | Processor reset, active low |
| mcu_clk_en_o | output | 1 | Processor slow-clock enable |
| periph_clk_en_o | output | 1 | Peripheral clock enable |
| dom_on_o | output | N_DOM | Per-domain power requests |
| warm_irq_o | output | 1 | Warm-start interrupt flag |
| mh_irq_o | output | 1 | Memory-hold interrupt flag |
| mode_o | output | 3 | Current mode code |

## Verification
Every output is due one clock edge after the input that causes it. Mode, resets, domain requests, clock enables and flags all update on the same edge that samples the command or configuration. The only exception is a timer expiry, which moves the mode `RST_TICKS`+1 edges after entry into Cold Start or Warm Start. The bench drives inputs on the falling edge. A model advances on the rising edge using those same inputs, and all outputs are compared at the next falling edge. The directed phase also counts falling edges from a turn-on to the Watchdog code, to check the exact timed-state length.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [2:0] {
    M_OFF   = 3'd0,
    M_COLD  = 3'd1,
    M_RUN   = 3'd2,
    M_UOFF  = 3'd3,
    M_MHOLD = 3'd4,
    M_WARM  = 3'd5
  } mode_t;

  function automatic logic timed_mode(mode_t m);
    return (m == M_COLD) || (m == M_WARM);
  endfunction
endpackage

// File: rtl/lpm_rst_timer.sv
module lpm_rst_timer #(
  parameter int TMR_W     = 16,
  parameter int RST_TICKS = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic load_i,
  input  logic run_i,
  output logic expire_o
);
  localparam logic [TMR_W-1:0] PRESET = TMR_W'(RST_TICKS);

  logic [TMR_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                       cnt_q <= '0;
    else if (load_i)               cnt_q <= PRESET;
    else if (run_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign expire_o = run_i && (cnt_q == '0);

  // expiry is a single-cycle pulse unless a new load follows
  assert_expire_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    (expire_o && !load_i) |=> !expire_o);
  // a load always restarts a full countdown
  assert_load_no_expire_R2: assert property (@(posedge clk) disable iff (rst)
    (load_i && RST_TICKS > 0) |=> !expire_o);
endmodule

// File: rtl/lpm_out_reg.sv
module lpm_out_reg
  import lpm_pkg::*;
#(
  parameter int N_DOM = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  mode_t            mode_d,
  input  logic             from_mh_d,
  input  logic             mcu_clk_en_i,
  input  logic             uo_clk_keep_i,
  input  logic             clk_retain_i,
  input  logic [N_DOM-1:0] uo_keep_i,
  input  logic [N_DOM-1:0] mh_keep_i,
  output logic             periph_rst_n_o,
  output logic             proc_rst_n_o,
  output logic             mcu_clk_en_o,
  output logic             periph_clk_en_o,
  output logic [N_DOM-1:0] dom_on_o
);
  logic             prst_d, crst_d, mclk_d, pclk_d;
  logic [N_DOM-1:0] dom_d;

  always_comb begin
    prst_d = 1'b0;
    crst_d = 1'b0;
    mclk_d = 1'b0;
    pclk_d = 1'b0;
    dom_d  = '0;
    case (mode_d)
      M_RUN: begin
        prst_d = 1'b1;
        crst_d = 1'b1;
        mclk_d = mcu_clk_en_i;
        pclk_d = 1'b1;
        dom_d  = '1;
      end
      M_UOFF: begin
        crst_d = 1'b1;
        mclk_d = (mcu_clk_en_i & uo_clk_keep_i) | clk_retain_i;
        dom_d  = uo_keep_i;
      end
      M_WARM: begin
        crst_d = 1'b1;
        mclk_d = mcu_clk_en_i;
        dom_d  = uo_keep_i;
      end
      M_MHOLD: dom_d = mh_keep_i;
      M_COLD:  dom_d = from_mh_d ? mh_keep_i : '0;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      periph_rst_n_o  <= 1'b0;
      proc_rst_n_o    <= 1'b0;
      mcu_clk_en_o    <= 1'b0;
      periph_clk_en_o <= 1'b0;
      dom_on_o        <= '0;
    end else begin
      periph_rst_n_o  <= prst_d;
      proc_rst_n_o    <= crst_d;
      mcu_clk_en_o    <= mclk_d;
      periph_clk_en_o <= pclk_d;
      dom_on_o        <= dom_d;
    end
  end

  // peripheral reset released only together with processor reset
  assert_rst_order_R3: assert property (@(posedge clk) disable iff (rst)
    periph_rst_n_o |-> proc_rst_n_o);
  // peripheral clock only runs while peripherals are out of reset
  assert_pclk_R4: assert property (@(posedge clk) disable iff (rst)
    periph_clk_en_o |-> periph_rst_n_o);
endmodule

// File: rtl/lpm_state_ctrl.sv
module lpm_state_ctrl
  import lpm_pkg::*;
#(
  parameter int N_DOM     = 4,
  parameter int TMR_W     = 16,
  parameter int RST_TICKS = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             turn_on_i,
  input  logic             pwr_cut_i,
  input  logic             user_off_cmd_i,
  input  logic             mem_hold_cmd_i,
  input  logic             irq_clr_i,
  input  logic             mcu_clk_en_i,
  input  logic             uo_clk_keep_i,
  input  logic             clk_retain_i,
  input  logic [N_DOM-1:0] uo_keep_i,
  input  logic [N_DOM-1:0] mh_keep_i,
  output logic             periph_rst_n_o,
  output logic             proc_rst_n_o,
  output logic             mcu_clk_en_o,
  output logic             periph_clk_en_o,
  output logic [N_DOM-1:0] dom_on_o,
  output logic             warm_irq_o,
  output logic             mh_irq_o,
  output logic [2:0]       mode_o
);
  mode_t mode_q, mode_d;
  logic  from_mh_q, from_mh_d;
  logic  expire, tmr_load, tmr_run;
  logic  warm_set, mh_set;

  always_comb begin
    mode_d = mode_q;
    if (pwr_cut_i) mode_d = M_OFF;
    else begin
      case (mode_q)
        M_OFF:   if (turn_on_i) mode_d = M_COLD;
        M_COLD:  if (expire) mode_d = M_RUN;
        M_RUN:   if (user_off_cmd_i) mode_d = M_UOFF;
                 else if (mem_hold_cmd_i) mode_d = M_MHOLD;
        M_UOFF:  if (turn_on_i) mode_d = M_WARM;
        M_MHOLD: if (turn_on_i) mode_d = M_COLD;
        M_WARM:  if (expire) mode_d = M_RUN;
        default: mode_d = M_OFF;
      endcase
    end
  end

  assign from_mh_d = (mode_d == M_COLD) && ((mode_q == M_MHOLD) || from_mh_q);
  assign tmr_run   = timed_mode(mode_q);
  assign tmr_load  = timed_mode(mode_d) && (mode_d != mode_q);
  assign warm_set  = (mode_q == M_WARM) && (mode_d == M_RUN);
  assign mh_set    = (mode_q == M_MHOLD) && (mode_d == M_COLD);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q     <= M_OFF;
      from_mh_q  <= 1'b0;
      warm_irq_o <= 1'b0;
      mh_irq_o   <= 1'b0;
    end else begin
      mode_q     <= mode_d;
      from_mh_q  <= from_mh_d;
      warm_irq_o <= warm_set | (warm_irq_o & ~irq_clr_i);
      mh_irq_o   <= mh_set | (mh_irq_o & ~irq_clr_i);
    end
  end

  assign mode_o = mode_q;

  lpm_rst_timer #(.TMR_W(TMR_W), .RST_TICKS(RST_TICKS)) tmr_i (
    .clk(clk), .rst(rst), .load_i(tmr_load), .run_i(tmr_run), .expire_o(expire)
  );

  lpm_out_reg #(.N_DOM(N_DOM)) out_i (
    .clk(clk), .rst(rst), .mode_d(mode_d), .from_mh_d(from_mh_d),
    .mcu_clk_en_i(mcu_clk_en_i), .uo_clk_keep_i(uo_clk_keep_i),
    .clk_retain_i(clk_retain_i), .uo_keep_i(uo_keep_i), .mh_keep_i(mh_keep_i),
    .periph_rst_n_o(periph_rst_n_o), .proc_rst_n_o(proc_rst_n_o),
    .mcu_clk_en_o(mcu_clk_en_o), .periph_clk_en_o(periph_clk_en_o),
    .dom_on_o(dom_on_o)
  );

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (mode_o == 3'd0 && !proc_rst_n_o && !periph_rst_n_o && dom_on_o == '0));
  assert_uoff_rst_R4: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 3'd3) |-> (proc_rst_n_o && !periph_rst_n_o));
  assert_mhold_rst_R6: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 3'd4) |-> (!proc_rst_n_o && !periph_rst_n_o));
  assert_warm_irq_R9: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 3'd5 && !pwr_cut_i && expire) |=> (warm_irq_o && periph_rst_n_o));
  assert_mh_irq_R8: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 3'd4 && turn_on_i && !pwr_cut_i) |=> (mh_irq_o && mode_o == 3'd1));
  assert_clear_R10: assert property (@(posedge clk) disable iff (rst)
    (irq_clr_i && mode_o != 3'd5 && mode_o != 3'd4) |=> (!warm_irq_o && !mh_irq_o));
  assert_pcut_R11: assert property (@(posedge clk) disable iff (rst)
    pwr_cut_i |=> (mode_o == 3'd0 && !proc_rst_n_o));
  assert_lp_hold_R12: assert property (@(posedge clk) disable iff (rst)
    ((mode_o == 3'd3 || mode_o == 3'd4) && !turn_on_i && !pwr_cut_i) |=> $stable(mode_o));
endmodule

// File: tb/lpm_state_ctrl_tb_top.sv
module lpm_state_ctrl_tb_top;
  localparam int ND = 4;
  localparam int TK = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic turn_on = 0, pcut = 0, uo_cmd = 0, mh_cmd = 0, clr = 0;
  logic mcu_en = 0, uo_clk = 0, retain = 0;
  logic [ND-1:0] uo_keep = '0, mh_keep = '0;
  logic prst_n, crst_n, mclk, pclk, wirq, mirq;
  logic [ND-1:0] dom;
  logic [2:0] mode;

  int n_chk = 0, n_fail = 0, cyc = 0;
  string tag = "R1";

  always #5 clk = ~clk;

  lpm_state_ctrl #(.N_DOM(ND), .TMR_W(16), .RST_TICKS(TK)) dut_i (
    .clk(clk), .rst(rst), .turn_on_i(turn_on), .pwr_cut_i(pcut),
    .user_off_cmd_i(uo_cmd), .mem_hold_cmd_i(mh_cmd), .irq_clr_i(clr),
    .mcu_clk_en_i(mcu_en), .uo_clk_keep_i(uo_clk), .clk_retain_i(retain),
    .uo_keep_i(uo_keep), .mh_keep_i(mh_keep),
    .periph_rst_n_o(prst_n), .proc_rst_n_o(crst_n), .mcu_clk_en_o(mclk),
    .periph_clk_en_o(pclk), .dom_on_o(dom), .warm_irq_o(wirq), .mh_irq_o(mirq),
    .mode_o(mode)
  );

  // reference model, written from the requirements
  int m_st = 0, m_cnt = 0;
  logic m_fmh = 0, m_w = 0, m_m = 0;
  logic e_prst = 0, e_crst = 0, e_mclk = 0, e_pclk = 0;
  logic [ND-1:0] e_dom = '0;

  function automatic int next_mode(int s, bit exp);
    if (pcut) return 0;
    case (s)
      0: return turn_on ? 1 : 0;
      1: return exp ? 2 : 1;
      2: return uo_cmd ? 3 : (mh_cmd ? 4 : 2);
      3: return turn_on ? 5 : 3;
      4: return turn_on ? 1 : 4;
      5: return exp ? 2 : 5;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    int ns;
    bit ex, fmh;
    if (rst) begin
      m_st <= 0; m_cnt <= 0; m_fmh <= 0; m_w <= 0; m_m <= 0;
      e_prst <= 0; e_crst <= 0; e_mclk <= 0; e_pclk <= 0; e_dom <= '0;
    end else begin
      ex  = (m_st == 1 || m_st == 5) && m_cnt == 0;
      ns  = next_mode(m_st, ex);
      fmh = (ns == 1) && (m_st == 4 || m_fmh);
      m_st  <= ns;
      m_fmh <= fmh;
      if ((ns == 1 || ns == 5) && ns != m_st) m_cnt <= TK;
      else if ((m_st == 1 || m_st == 5) && m_cnt != 0) m_cnt <= m_cnt - 1;
      m_w <= (m_st == 5 && ns == 2) | (m_w & ~clr);
      m_m <= (m_st == 4 && ns == 1) | (m_m & ~clr);
      e_prst <= (ns == 2);
      e_crst <= (ns == 2 || ns == 3 || ns == 5);
      e_pclk <= (ns == 2);
      e_mclk <= (ns == 2 || ns == 5) ? mcu_en :
                (ns == 3) ? ((mcu_en & uo_clk) | retain) : 1'b0;
      e_dom  <= (ns == 2) ? '1 : (ns == 3 || ns == 5) ? uo_keep :
                (ns == 4 || (ns == 1 && fmh)) ? mh_keep : '0;
    end
  end

  task automatic check(string t, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", t, what, act, exp, cyc);
    end
  endtask

  task automatic compare_all();
    check(tag, "mode", mode, m_st);
    check(tag, "periph_rst_n", prst_n, e_prst);
    check(tag, "proc_rst_n", crst_n, e_crst);
    check(tag, "dom_on", dom, e_dom);
    check(tag, "mcu_clk_en", mclk, e_mclk);
    check(tag, "periph_clk_en", pclk, e_pclk);
    check(tag, "warm_irq", wirq, m_w);
    check(tag, "mh_irq", mirq, m_m);
  endtask

  // one cycle: compare at the falling edge, then drive new inputs
  task automatic step();
    @(negedge clk);
    compare_all();
    turn_on = 0; pcut = 0; uo_cmd = 0; mh_cmd = 0; clr = 0;
  endtask

  task automatic wait_cycles(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  function automatic int run_len_expect();
    return TK + 1;
  endfunction

  task automatic measure_to_run(string t);
    int len = 0;
    while (mode != 3'd2 && len < 10 * TK) begin
      step();
      len++;
    end
    check(t, "timed state length", len, run_len_expect());
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired: actual %0d expected below 100000", cyc);
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1;
    mcu_en = 1; uo_clk = 1; uo_keep = 4'b1010; mh_keep = 4'b0100;
    wait_cycles(3);
    // R1: reset state
    tag = "R1";
    check("R1", "mode after reset", mode, 0);
    check("R1", "proc_rst_n after reset", crst_n, 0);
    @(negedge clk); rst = 0;

    // R12: turn_on ignored? no, Off accepts it; commands ignored in Off
    tag = "R12";
    uo_cmd = 1; mh_cmd = 1; step();
    check("R12", "commands in Off", mode, 0);

    // R2: cold boot from Off
    tag = "R2";
    turn_on = 1;
    step();
    check("R2", "cold start entered", mode, 1);
    measure_to_run("R2");

    // R3: running state
    tag = "R3";
    mcu_en = 0; step(); step();
    check("R3", "dom all on", dom, 4'hF);
    turn_on = 1; step();
    check("R12", "turn_on ignored in Watchdog", mode, 2);

    // R4, R5: user off (both commands: user off wins, R6)
    tag = "R4";
    mcu_en = 1; uo_clk = 0; retain = 0;
    uo_cmd = 1; mh_cmd = 1; step();
    check("R6", "user off wins over mem hold", mode, 3);
    tag = "R5";
    step();
    check("R5", "mcu clk off without keep", mclk, 0);
    retain = 1; step(); step();
    check("R5", "mcu clk kept by retain", mclk, 1);
    retain = 0; uo_clk = 1; step(); step();
    check("R5", "mcu clk kept by both bits", mclk, 1);

    // R12: User Off persists far beyond timer length
    tag = "R12";
    wait_cycles(5 * TK);
    check("R12", "user off persists", mode, 3);

    // R7, R9: warm start
    tag = "R7";
    turn_on = 1; step();
    check("R7", "warm start entered", mode, 5);
    check("R7", "warm proc_rst_n high", crst_n, 1);
    check("R7", "warm domains keep", dom, uo_keep);
    measure_to_run("R7");
    tag = "R9";
    check("R9", "warm irq set", wirq, 1);
    check("R9", "periph reset released", prst_n, 1);

    // R10: clear
    tag = "R10";
    clr = 1; step(); step();
    check("R10", "warm irq cleared", wirq, 0);

    // R6, R8: memory hold and cold return
    tag = "R6";
    mh_cmd = 1; step();
    check("R6", "mem hold entered", mode, 4);
    check("R6", "mem hold domains", dom, mh_keep);
    wait_cycles(3 * TK);
    check("R12", "mem hold persists", mode, 4);
    tag = "R8";
    turn_on = 1; clr = 1; step();
    check("R8", "cold from mem hold", mode, 1);
    check("R10", "set wins over clear", mirq, 1);
    check("R8", "cold domains from mem hold", dom, mh_keep);
    uo_cmd = 1; turn_on = 1; step();
    check("R12", "cmds ignored in Cold", mode, 1);

    // R11: power cut mid-cold
    tag = "R11";
    pcut = 1; turn_on = 1; step();
    check("R11", "power cut to Off", mode, 0);

    // random phase
    tag = "R11";
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      compare_all();
      pcut    = ($urandom % 150) == 0;
      turn_on = ($urandom % 6) == 0;
      uo_cmd  = ($urandom % 12) == 0;
      mh_cmd  = ($urandom % 12) == 0;
      clr     = ($urandom % 20) == 0;
      if (($urandom % 40) == 0) begin
        mcu_en = $urandom; uo_clk = $urandom; retain = $urandom;
        uo_keep = ND'($urandom); mh_keep = ND'($urandom);
      end
    end
    step();
    // R1: reset from a running mode
    rst = 1; step();
    check("R1", "reset again", mode, 0);
    check("R1", "flags cleared", int'(wirq) + int'(mirq), 0);
    finish_run();
  end
endmodule